// File: doc/BRIEF.md
# Strip-Parallel 3x3 Maximum Filter

This block runs a 3x3 maximum (grey-scale dilation) filter over an 8-bit image held in an external word memory. Each 32-bit memory word carries four vertically adjacent pixels of one column. The filter works through the image in horizontal strips six rows tall. For each column step of a strip it brings in one new word and produces four output pixels stacked on top of one another. Those four outputs go back to memory as one packed word.

Two rows are shared between neighbouring strips. At the moment they arrive, the block copies them into an on-chip two-port line store. The next strip reads them back in the same cycle in which it fetches its four new rows, so every input word is read from memory exactly once.

A sequencer keeps a read in flight on every cycle of a job, with no seam between columns or strips. The very first strip has no stored rows yet, so the job begins with one priming sweep that fills the line store and writes nothing. The host gives the width, the strip count and the two base addresses, pulses `start`, and waits for `done`.

Top module: `max3_strip_filter`

## Requirements
- R1: After reset `busy`, `done`, `rd_en` and `wr_en` are all low.
- R2: A `start` pulse in idle with width W (3 to MAX_WIDTH) and strip count K (at least 1) raises `busy` on the next cycle. From that cycle on, `rd_en` stays high for exactly (K+1)*W consecutive cycles, at addresses `cfg_src`, `cfg_src`+1, and so on.
- R3: Input layout: the word at `cfg_src` + q*W + c holds column c, with bits 8b+7:8b carrying image row 4q+b-2. Bytes 0 and 1 of the q=0 words are padding and are never used. The image height is 4K+2.
- R4: Each result pixel (r, x) is the unsigned maximum of input rows r..r+2 and columns x..x+2, for r in 0..4K-1 and x in 0..W-3.
- R5: Output layout: the word at `cfg_dst` + k*(W-2) + x holds result rows 4k..4k+3 of column x, with bits 8i+7:8i carrying row 4k+i. Words are written in strictly ascending address order.
- R6: The result word for strip k, column x appears on the write port exactly 3 cycles after the read of word (k+1)*W + x + 2. The only cycles without a write are the first two column steps of each strip.
- R7: Every input word is read exactly once per job. The two rows shared between strips come from the line store.
- R8: `done` is a one-cycle pulse in the cycle after the final write, and `busy` falls in that same cycle.
- R9: While `busy` is high, `start` and all configuration inputs are ignored; the read and write streams of the running job do not change.
- R10: A `start` in idle with W < 3 or K = 0 raises `done` for one cycle on the next cycle, leaves `busy` low, and causes no read or write.
- R11: Pixels compare as unsigned, so 0xFF wins any window it lies in. A value in a row that comes from the line store counts exactly like a freshly read one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job request, taken only in idle |
| cfg_width | input | WIDTH_W | Image width W in pixels |
| cfg_strips | input | STRIP_W | Number of output strips K |
| cfg_src | input | ADDR_W | Word address of the input image |
| cfg_dst | input | ADDR_W | Word address of the result image |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 32 | Read data, valid the cycle after the request |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 32 | Packed result word |

## Verification
The hardest situation to reach is a large value that sits only in the two rows carried between strips. In that case a correct result depends entirely on the line store, since those rows are never fetched again. One stimulus image is zero except for 0xFF and mid-range impulses placed in those carried rows and in the first and last columns. The padding bytes are filled with 0xFF, so any use of them changes the results. A second `start` with a different configuration is pulsed mid-job to show that it is ignored. The reference model rebuilds every expected write from the image and compares the read stream, the write stream and `done` on every cycle.

// File: rtl/max3_pkg.sv
package max3_pkg;

    localparam int PIX_W  = 8;
    localparam int LANES  = 4;
    localparam int ROWS   = LANES + 2;
    localparam int WORD_W = PIX_W * LANES;
    localparam int KEEP_W = 2 * PIX_W;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    function automatic pix_t pix_max(input pix_t a, input pix_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/max3_linebuf.sv
module max3_linebuf #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];
    logic [DW-1:0] rdata_q;

    // Two-port storage: one write and one registered read per cycle
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata_q <= store[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/max3_vert.sv
module max3_vert
    import max3_pkg::*;
(
    input  logic [KEEP_W-1:0] kept_rows,
    input  logic [WORD_W-1:0] new_rows,
    output logic [WORD_W-1:0] vmax
);
    pix_t col [ROWS];

    // Column slot 0/1 come from the line store, slots 2..5 from memory
    assign col[0] = kept_rows[PIX_W-1:0];
    assign col[1] = kept_rows[KEEP_W-1:PIX_W];

    for (genvar r = 0; r < LANES; r++) begin : g_fresh
        assign col[r+2] = new_rows[r*PIX_W +: PIX_W];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign vmax[i*PIX_W +: PIX_W] = pix_max(pix_max(col[i], col[i+1]), col[i+2]);
    end
endmodule

// File: rtl/max3_horiz.sv
module max3_horiz
    import max3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              emit,
    input  logic [WORD_W-1:0] vmax_in,
    output logic [WORD_W-1:0] out_word
);
    typedef struct packed {
        logic [WORD_W-1:0] v0;
        logic [WORD_W-1:0] v1;
        logic [WORD_W-1:0] v2;
        logic [WORD_W-1:0] out;
    } hz_t;

    hz_t q, d;
    logic [WORD_W-1:0] hmax;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign hmax[i*PIX_W +: PIX_W] =
            pix_max(pix_max(q.v0[i*PIX_W +: PIX_W], q.v1[i*PIX_W +: PIX_W]),
                    q.v2[i*PIX_W +: PIX_W]);
    end

    always_comb begin
        d = q;
        if (shift_en) begin
            d.v0 = vmax_in;
            d.v1 = q.v0;
            d.v2 = q.v1;
        end
        if (emit) begin
            d.out = hmax;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_word = q.out;
endmodule

// File: rtl/max3_seq.sv
module max3_seq
    import max3_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int WIDTH_W = 9,
    parameter int STRIP_W = 8,
    parameter int LB_AW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [STRIP_W-1:0] cfg_strips,
    input  logic [ADDR_W-1:0]  cfg_src,
    input  logic [ADDR_W-1:0]  cfg_dst,
    output logic               busy,
    output logic               done,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [LB_AW-1:0]   lb_raddr,
    output logic               lb_we,
    output logic [LB_AW-1:0]   lb_waddr,
    output logic               shift_en,
    output logic               emit,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr
);
    typedef struct packed {
        seq_state_e         st;
        logic [WIDTH_W-1:0] width;
        logic [STRIP_W-1:0] strips;
        logic [ADDR_W-1:0]  rd_addr;
        logic [ADDR_W-1:0]  wr_addr;
        logic [WIDTH_W-1:0] col;
        logic [STRIP_W:0]   pass;
        logic               s1_v;
        logic               s1_prime;
        logic               s1_last;
        logic [WIDTH_W-1:0] s1_col;
        logic               s2_v;
        logic               s2_prime;
        logic               s2_last;
        logic [WIDTH_W-1:0] s2_col;
        logic               out_v;
        logic               out_last;
        logic               done;
    } seq_t;

    seq_t q, d;
    logic issue, col_end, pass_end, emit_c;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        issue    = (q.st == ST_RUN);
        col_end  = (q.col == q.width - 1'b1);
        pass_end = (q.pass == {1'b0, q.strips});
        emit_c   = q.s2_v && !q.s2_prime && (q.s2_col >= WIDTH_W'(2));

        // tag pipeline: issue -> data arrival -> vertical stage -> write port
        d.s1_v     = issue;
        d.s1_prime = (q.pass == '0);
        d.s1_col   = q.col;
        d.s1_last  = issue && col_end && pass_end;
        d.s2_v     = q.s1_v;
        d.s2_prime = q.s1_prime;
        d.s2_col   = q.s1_col;
        d.s2_last  = q.s1_last;
        d.out_v    = emit_c;
        d.out_last = q.s2_last;

        if (q.out_v) begin
            d.wr_addr = q.wr_addr + 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if ((cfg_width < WIDTH_W'(3)) || (cfg_strips == '0)) begin
                        d.done = 1'b1;
                    end else begin
                        d.st      = ST_RUN;
                        d.width   = cfg_width;
                        d.strips  = cfg_strips;
                        d.rd_addr = cfg_src;
                        d.wr_addr = cfg_dst;
                        d.col     = '0;
                        d.pass    = '0;
                    end
                end
            end
            ST_RUN: begin
                d.rd_addr = q.rd_addr + 1'b1;
                if (col_end) begin
                    d.col  = '0;
                    d.pass = q.pass + 1'b1;
                    if (pass_end) begin
                        d.st = ST_DRAIN;
                    end
                end else begin
                    d.col = q.col + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (q.out_v && q.out_last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign rd_en    = issue;
    assign rd_addr  = q.rd_addr;
    assign lb_raddr = q.col[LB_AW-1:0];
    assign lb_we    = q.s1_v;
    assign lb_waddr = q.s1_col[LB_AW-1:0];
    assign shift_en = q.s1_v;
    assign emit     = emit_c;
    assign wr_en    = q.out_v;
    assign wr_addr  = q.wr_addr;
endmodule

// File: rtl/max3_strip_filter.sv
module max3_strip_filter
    import max3_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_WIDTH = 256,
    parameter int STRIP_W   = 8,
    localparam int WIDTH_W  = $clog2(MAX_WIDTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [STRIP_W-1:0] cfg_strips,
    input  logic [ADDR_W-1:0]  cfg_src,
    input  logic [ADDR_W-1:0]  cfg_dst,
    output logic               busy,
    output logic               done,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [31:0]        rd_data,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [31:0]        wr_data
);
    localparam int LB_AW = $clog2(MAX_WIDTH);

    logic [LB_AW-1:0]  lb_raddr, lb_waddr;
    logic              lb_we, shift_en, emit;
    logic [KEEP_W-1:0] kept_rows;
    logic [WORD_W-1:0] vmax;

    max3_seq #(
        .ADDR_W (ADDR_W),
        .WIDTH_W(WIDTH_W),
        .STRIP_W(STRIP_W),
        .LB_AW  (LB_AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_width (cfg_width),
        .cfg_strips(cfg_strips),
        .cfg_src   (cfg_src),
        .cfg_dst   (cfg_dst),
        .busy      (busy),
        .done      (done),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .lb_raddr  (lb_raddr),
        .lb_we     (lb_we),
        .lb_waddr  (lb_waddr),
        .shift_en  (shift_en),
        .emit      (emit),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr)
    );

    // bottom two rows of each fetched word are kept for the next strip
    max3_linebuf #(
        .AW(LB_AW),
        .DW(KEEP_W)
    ) u_linebuf (
        .clk  (clk),
        .we   (lb_we),
        .waddr(lb_waddr),
        .wdata(rd_data[WORD_W-1:WORD_W-KEEP_W]),
        .raddr(lb_raddr),
        .rdata(kept_rows)
    );

    max3_vert u_vert (
        .kept_rows(kept_rows),
        .new_rows (rd_data),
        .vmax     (vmax)
    );

    max3_horiz u_horiz (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .emit    (emit),
        .vmax_in (vmax),
        .out_word(wr_data)
    );
endmodule

// File: rtl/max3_strip_filter_chk.sv
module max3_strip_filter_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);
    logic [ADDR_W-1:0] last_wr;
    logic              have_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wr <= '0;
            have_wr <= 1'b0;
        end else begin
            if (wr_en) begin
                last_wr <= wr_addr;
            end
            have_wr <= busy ? (have_wr | wr_en) : 1'b0;
        end
    end

    // R2
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R6
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    // R6
    wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R5
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have_wr) |-> (wr_addr == last_wr + 1'b1));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind max3_strip_filter max3_strip_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .wr_en  (wr_en),
    .wr_addr(wr_addr)
);

// File: tb/max3_strip_filter_bench.sv
module max3_strip_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 16;
    localparam int MAXW = 256;
    localparam int SW   = 8;
    localparam int WW   = $clog2(MAXW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [WW-1:0] cfg_width = '0;
    logic [SW-1:0] cfg_strips = '0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic          busy, done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [31:0]   rd_data = '0;
    logic [31:0]   wr_data;

    int tests = 0;
    int fails = 0;

    logic [7:0]  img [0:31][0:15];
    logic [31:0] mem [0:4095];

    max3_strip_filter #(.ADDR_W(AW), .MAX_WIDTH(MAXW), .STRIP_W(SW)) u_max3_strip_filter (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_strips(cfg_strips),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // external memory: one-cycle read latency
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr[11:0]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input int k, input int x);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] m = 8'h00;
            for (int rr = 0; rr < 3; rr++)
                for (int cc = 0; cc < 3; cc++)
                    if (img[4*k+i+rr][x+cc] > m) m = img[4*k+i+rr][x+cc];
            w[8*i +: 8] = m;
        end
        return w;
    endfunction

    // R3: word q, column c, byte b holds row 4q+b-2; padding filled with 0xFF
    task automatic load_image(input int w, input int k, input int src);
        for (int q = 0; q <= k; q++)
            for (int c = 0; c < w; c++)
                for (int b = 0; b < 4; b++) begin
                    int r = 4*q + b - 2;
                    mem[src + q*w + c][8*b +: 8] = (r < 0) ? 8'hFF : img[r][c];
                end
    endtask

    task automatic clear_image();
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 16; c++) img[r][c] = 8'h00;
    endtask

    task automatic random_image();
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 16; c++) img[r][c] = 8'($urandom);
    endtask

    task automatic run_job(input int w, input int k, input int src, input int dst,
                           input string tag, input bit poke);
        int total = (k + 1) * w;
        int reads = 0;
        load_image(w, k, src);
        @(negedge clk);
        cfg_width = WW'(w); cfg_strips = SW'(k);
        cfg_src = AW'(src); cfg_dst = AW'(dst);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= total + 4; j++) begin
            bit exp_rd = (j < total);
            bit exp_wr = 1'b0;
            int kk = 0;
            int xx = 0;
            check(rd_en === exp_rd, "R2", "rd_en", 32'(rd_en), 32'(exp_rd));
            if (exp_rd) check(rd_addr === AW'(src + j), "R2", "rd_addr", 32'(rd_addr), 32'(src + j));
            if (rd_en === 1'b1) reads++;
            if (j >= 3 && (j - 3) < total) begin
                int n = j - 3;
                if ((n / w) >= 1 && (n % w) >= 2) begin
                    exp_wr = 1'b1;
                    kk = n / w - 1;
                    xx = n % w - 2;
                end
            end
            check(wr_en === exp_wr, "R6", "wr_en", 32'(wr_en), 32'(exp_wr));
            if (exp_wr) begin
                check(wr_addr === AW'(dst + kk*(w-2) + xx), "R5", "wr_addr",
                      32'(wr_addr), 32'(dst + kk*(w-2) + xx));
                check(wr_data === expect_word(kk, xx), {"R4 ", tag}, "wr_data",
                      wr_data, expect_word(kk, xx));
            end
            check(done === (j == total + 3), "R8", "done", 32'(done), 32'(j == total + 3));
            check(busy === (j < total + 3), "R8", "busy", 32'(busy), 32'(j < total + 3));
            // R9: a second request with another shape mid-job must change nothing
            if (poke && (j == 4 || j == 5)) begin
                cfg_width = WW'(3); cfg_strips = SW'(1); cfg_src = '0; cfg_dst = '0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(reads == total, "R7", "read count", 32'(reads), 32'(total));
    endtask

    // R10: degenerate shape
    task automatic run_bad(input int w, input int k);
        @(negedge clk);
        cfg_width = WW'(w); cfg_strips = SW'(k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < 4; j++) begin
            check(done === (j == 0), "R10", "done", 32'(done), 32'(j == 0));
            check(busy === 1'b0, "R10", "busy", 32'(busy), 32'd0);
            check(rd_en === 1'b0 && wr_en === 1'b0, "R10", "rd/wr", 32'({rd_en, wr_en}), 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        // R1
        check({busy, done, rd_en, wr_en} === 4'b0, "R1", "reset outputs", 32'({busy, done, rd_en, wr_en}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, rd_en, wr_en} === 4'b0, "R1", "idle outputs", 32'({busy, done, rd_en, wr_en}), 32'd0);

        random_image();
        run_job(5, 1, 16, 512, "R3 random", 1'b0);

        random_image();
        run_job(3, 2, 100, 600, "narrow", 1'b0);

        // R11: impulses in carried rows, edge columns and padding
        clear_image();
        img[4][1] = 8'hFF; img[5][7] = 8'h80; img[9][6] = 8'hFF;
        img[8][0] = 8'h7F; img[13][7] = 8'h81; img[12][4] = 8'hFE;
        run_job(8, 3, 200, 700, "R11 impulse R9", 1'b1);

        run_bad(2, 1);
        run_bad(6, 0);

        random_image();
        run_job(16, 4, 300, 900, "wide", 1'b0);

        random_image();
        run_job(4, 1, 1000, 1100, "back-to-back", 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule